// File: doc/BRIEF.md
# Split Code/Data Relocation and Protection Unit

This block sits between a processor core and its memory path. It turns each logical address into a physical one, and it guards against accesses that fall outside the process's allotted regions. It holds two relocation windows. A code window serves instruction fetches. A data window serves loads and stores. Each window is a base register paired with a limit register. An unprivileged request whose offset lies below the selected limit is issued at base plus offset. An offset at or beyond the limit faults.

The code window is read-only as seen from the data side. A store whose relocated address lands anywhere inside the code window is refused, so several processes can map the same code safely. Privileged requests bypass relocation entirely. Only a privileged configuration write may change the four registers. A write without privilege is dropped and flagged on a separate one-cycle status output.

The request side has no back-pressure. A request is taken on every cycle in which `req_valid` is high. Its result appears exactly one cycle later, with `rsp_valid` high for that single cycle. The consumer must accept each result in the cycle it is presented.

Top module: `dual_relocator`

## Requirements
- R1: While reset is low, rsp_valid and cfg_fault are 0. Reset clears all four registers to zero, so the first unprivileged request of any kind after reset faults with code 01.
- R2: cfg_sel selects the register to write: 00 code base, 01 code limit, 10 data base, 11 data limit. A write with cfg_priv=1 loads cfg_data and reports cfg_fault=00 in the next cycle. A write with cfg_priv=0 changes no register and reports cfg_fault=11 in the next cycle.
- R3: req_kind encodes the access type: 00 instruction fetch, 01 data read, 10 data write, 11 data read. Fetches use the code window. All other kinds use the data window.
- R4: An unprivileged request whose offset is below the selected limit returns rsp_addr = base + offset, modulo 2^32, with rsp_fault=00.
- R5: An unprivileged request whose offset is greater than or equal to the selected limit (unsigned) returns rsp_fault=01 and rsp_addr=0. This holds even if the relocated address would hit the code window.
- R6: An unprivileged data write that passes the limit check, but whose relocated address P satisfies (P - code base) mod 2^32 < code limit, returns rsp_fault=10 and rsp_addr=0.
- R7: Fetches and data reads never return rsp_fault=10.
- R8: A request with req_priv=1 returns rsp_addr = req_addr and rsp_fault=00, for any kind.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and low otherwise. Each result belongs to the request of the previous cycle.
- R10: A request made in the same cycle as a configuration write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present this cycle |
| req_kind | input | 2 | Access type (see R3) |
| req_priv | input | 1 | Request issued in privileged mode |
| req_addr | input | 32 | Logical address (offset into the window) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (see R2) |
| cfg_priv | input | 1 | Configuration write issued in privileged mode |
| cfg_data | input | 32 | Value to load |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Physical address, or 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 limit, 10 write to read-only, 11 unused here |
| cfg_fault | output | 2 | 00 accepted or idle, 11 privilege violation |

## Verification
A configuration write and a translation can land in the same cycle. The point in question is whether the translation sees the old register value or the new one. The bench provokes this by loading a new data base in the very cycle a data read is issued. That read must come back relocated by the previous base. The next read of the same offset must come back relocated by the new base. A second collision, between the limit check and the code-window write check, is provoked by stores that break the limit while landing inside the code window. Those stores must report the limit code.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_READ2 = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_LIMIT  = 2'b01,
    FLT_RDONLY = 2'b10,
    FLT_PRIV   = 2'b11
  } fault_e;

  localparam int unsigned NUM_WIN = 2;
  localparam int unsigned WIN_CODE = 0;
  localparam int unsigned WIN_DATA = 1;

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic          cfg_priv,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] base_o  [NUM_WIN],
  output logic [AW-1:0] limit_o [NUM_WIN],
  output fault_e        cfg_fault_o
);

  logic wr_ok;
  assign wr_ok = cfg_we && cfg_priv;

  // cfg_sel[1] picks the window, cfg_sel[0] picks limit over base
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic WSEL = (w == WIN_DATA);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_o[w]  <= '0;
        limit_o[w] <= '0;
      end else if (wr_ok && (cfg_sel[1] == WSEL)) begin
        if (cfg_sel[0]) limit_o[w] <= cfg_data;
        else            base_o[w]  <= cfg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    cfg_fault_o <= FLT_NONE;
    else if (cfg_we && !cfg_priv)  cfg_fault_o <= FLT_PRIV;
    else                           cfg_fault_o <= FLT_NONE;
  end

  // R2: an unprivileged write leaves every register untouched and is flagged
  a_r2_unpriv_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> ($stable(base_o[0]) && $stable(limit_o[0]) &&
                               $stable(base_o[1]) && $stable(limit_o[1]) &&
                               cfg_fault_o == FLT_PRIV));

  // R2: no unprivileged attempt means no flag
  a_r2_flag_only_on_attempt: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cfg_priv) |=> (cfg_fault_o == FLT_NONE));

  // R2: without a write strobe nothing moves
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(base_o[0]) && $stable(limit_o[1])));

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  acc_kind_e     kind_i,
  input  logic          priv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i  [NUM_WIN],
  input  logic [AW-1:0] limit_i [NUM_WIN],
  output logic [AW-1:0] phys_o,
  output fault_e        fault_o
);

  logic          use_data;
  logic [AW-1:0] sel_base;
  logic [AW-1:0] sel_limit;
  logic [AW-1:0] reloc;
  logic [AW-1:0] code_off;
  logic          in_limit;
  logic          hits_code;

  assign use_data  = (kind_i != ACC_FETCH);
  assign sel_base  = use_data ? base_i[WIN_DATA]  : base_i[WIN_CODE];
  assign sel_limit = use_data ? limit_i[WIN_DATA] : limit_i[WIN_CODE];
  assign reloc     = sel_base + addr_i;
  assign in_limit  = addr_i < sel_limit;
  // one wrap-safe compare decides membership of the code window
  assign code_off  = reloc - base_i[WIN_CODE];
  assign hits_code = code_off < limit_i[WIN_CODE];

  always_comb begin
    phys_o  = '0;
    fault_o = FLT_NONE;
    if (priv_i) begin
      phys_o = addr_i;
    end else if (!in_limit) begin
      fault_o = FLT_LIMIT;
    end else if (kind_i == ACC_WRITE && hits_code) begin
      fault_o = FLT_RDONLY;
    end else begin
      phys_o = reloc;
    end
  end

endmodule

// File: rtl/dual_relocator.sv
module dual_relocator
  import reloc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_priv,
  input  logic [AW-1:0] req_addr,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic          cfg_priv,
  input  logic [AW-1:0] cfg_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_fault,
  output logic [1:0]    cfg_fault
);

  logic [AW-1:0] win_base  [NUM_WIN];
  logic [AW-1:0] win_limit [NUM_WIN];
  logic [AW-1:0] xl_phys;
  fault_e        xl_fault;
  fault_e        cfg_fault_e;

  reloc_regs #(.AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_priv    (cfg_priv),
    .cfg_data    (cfg_data),
    .base_o      (win_base),
    .limit_o     (win_limit),
    .cfg_fault_o (cfg_fault_e)
  );

  reloc_xlate #(.AW(AW)) u_xlate (
    .kind_i  (acc_kind_e'(req_kind)),
    .priv_i  (req_priv),
    .addr_i  (req_addr),
    .base_i  (win_base),
    .limit_i (win_limit),
    .phys_o  (xl_phys),
    .fault_o (xl_fault)
  );

  assign cfg_fault = cfg_fault_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_addr  <= req_valid ? xl_phys : '0;
      rsp_fault <= req_valid ? xl_fault : FLT_NONE;
    end
  end

  // R9: one result per request, exactly one cycle later
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8: privileged requests pass through untouched
  a_r8_priv_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv) |=> (rsp_fault == FLT_NONE && rsp_addr == $past(req_addr)));

  // R7: only data writes may see the read-only fault
  a_r7_no_wp_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != ACC_WRITE) |=> (rsp_fault != FLT_RDONLY));

  // R5: a faulted result never carries an address
  a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_addr == '0));

endmodule

// File: tb/dual_relocator_tb_top.sv
`timescale 1ns/1ps
module dual_relocator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_priv = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'b00;
  logic        cfg_priv = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_fault;
  logic [1:0]  cfg_fault;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_relocator dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_priv(cfg_priv), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .cfg_fault(cfg_fault)
  );

  // kind, priv, offset, expected address, expected fault
  // code window 0x1000/0x100, data window 0xF80/0x400
  localparam logic [68:0] TBL [12] = '{
    {2'd2, 1'b0, 32'h0000_0080, 32'h0000_0000, 2'd2},  // R6 store onto code start
    {2'd2, 1'b0, 32'h0000_0010, 32'h0000_0F90, 2'd0},  // R4 plain store
    {2'd1, 1'b0, 32'h0000_0080, 32'h0000_1000, 2'd0},  // R7 load from code region
    {2'd2, 1'b0, 32'h0000_0180, 32'h0000_1100, 2'd0},  // R6 just past code end
    {2'd2, 1'b0, 32'h0000_017F, 32'h0000_0000, 2'd2},  // R6 last code byte
    {2'd2, 1'b0, 32'h0000_0400, 32'h0000_0000, 2'd1},  // R5 offset == limit
    {2'd1, 1'b0, 32'h0000_03FF, 32'h0000_137F, 2'd0},  // R5 limit - 1
    {2'd0, 1'b0, 32'h0000_00FF, 32'h0000_10FF, 2'd0},  // R3 fetch, code base
    {2'd0, 1'b0, 32'h0000_0100, 32'h0000_0000, 2'd1},  // R3 fetch over code limit
    {2'd3, 1'b0, 32'h0000_0020, 32'h0000_0FA0, 2'd0},  // R3 kind 11 reads data
    {2'd2, 1'b1, 32'h0000_0080, 32'h0000_0080, 2'd0},  // R8 privileged store
    {2'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0}   // R8 privileged fetch
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] k, input logic p, input logic [31:0] a,
                        output logic [31:0] oa, output logic [1:0] of, output logic ov);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_priv = p; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    oa = rsp_addr; of = rsp_fault; ov = rsp_valid;
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic p, input logic [31:0] d,
                           output logic [1:0] of);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_priv = p; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    of = cfg_fault;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [1:0]  f;
    logic        v;
    logic [1:0]  cf;

    // R1: outputs idle during reset
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 cfg_fault in reset", {30'd0, cfg_fault}, 32'd0);
    rst_n = 1'b1;

    // R1: cleared windows make unprivileged access fault
    do_req(2'd1, 1'b0, 32'h0, a, f, v);
    check("R1 read after reset fault", {30'd0, f}, 32'd1);
    check("R9 rsp_valid after request", {31'd0, v}, 32'd1);
    do_req(2'd0, 1'b0, 32'h5, a, f, v);
    check("R1 fetch after reset fault", {30'd0, f}, 32'd1);

    // R2: unprivileged write is rejected and changes nothing
    cfg_write(2'b11, 1'b0, 32'h0000_FFFF, cf);
    check("R2 unpriv write flag", {30'd0, cf}, 32'd3);
    do_req(2'd1, 1'b0, 32'h10, a, f, v);
    check("R2 data limit unchanged", {30'd0, f}, 32'd1);

    // R2: privileged loads
    cfg_write(2'b00, 1'b1, 32'h0000_1000, cf);
    check("R2 priv write no flag", {30'd0, cf}, 32'd0);
    cfg_write(2'b01, 1'b1, 32'h0000_0100, cf);
    cfg_write(2'b10, 1'b1, 32'h0000_0F80, cf);
    cfg_write(2'b11, 1'b1, 32'h0000_0400, cf);

    for (int i = 0; i < 12; i++) begin
      logic [1:0]  tk;
      logic        tp;
      logic [31:0] ta, ea;
      logic [1:0]  ef;
      {tk, tp, ta, ea, ef} = TBL[i];
      do_req(tk, tp, ta, a, f, v);
      check($sformatf("table[%0d] addr R3 R4 R5 R6 R7 R8", i), a, ea);
      check($sformatf("table[%0d] fault R3 R4 R5 R6 R7 R8", i), {30'd0, f}, {30'd0, ef});
    end

    // R9: no request, no strobe
    @(negedge clk);
    @(negedge clk);
    check("R9 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // R5 over R6: widen code window to 0x1000..0x1FFF
    cfg_write(2'b01, 1'b1, 32'h0000_1000, cf);
    do_req(2'd2, 1'b0, 32'h0000_0400, a, f, v);
    check("R5 limit beats write-protect", {30'd0, f}, 32'd1);
    do_req(2'd2, 1'b0, 32'h0000_03FF, a, f, v);
    check("R6 store into wide code window", {30'd0, f}, 32'd2);

    // R10: config write and request in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b10; cfg_priv = 1'b1; cfg_data = 32'h0000_2000;
    req_valid = 1'b1; req_kind = 2'd1; req_priv = 1'b0; req_addr = 32'h10;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R10 old base used", rsp_addr, 32'h0000_0F90);
    do_req(2'd1, 1'b0, 32'h10, a, f, v);
    check("R10 new base after", a, 32'h0000_2010);

    // R4: relocation wraps modulo 2^32
    cfg_write(2'b10, 1'b1, 32'hFFFF_FFF0, cf);
    do_req(2'd1, 1'b0, 32'h20, a, f, v);
    check("R4 wrap address", a, 32'h0000_0010);
    check("R4 wrap fault", {30'd0, f}, 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule